// File: doc/BRIEF.md
# FIFO-Fed I2C Master Transmitter

This block sends bytes onto an I2C bus as a master. The host pushes entries into a small transmit queue. Each entry holds one byte and two marker bits: one opens a transfer and one closes it. The block works on open-drain lines. It only pulls SCL or SDA low, and it senses the real level of each line on a separate input. It generates the START, shifts each byte out MSB first, samples the receiver's acknowledge, and issues a STOP once the closing byte has been acknowledged.

Several conditions raise a sticky status flag: a finished transfer, a lost arbitration, a refused byte, and a queue that runs dry in the middle of a transfer. In the last case the block does not end the transfer. It keeps SCL low so that the bus waits for more data. Each flag has an enable bit, and any flag that is set while its enable is set drives the single interrupt output. A soft-reset input puts the protocol engine back to idle without touching the flags.

Top module: `i2c_fifo_tx_master`

## Requirements
- R1: A queue entry is {close[9], open[8], byte[7:0]}. When the engine is idle, a head entry with open=1 starts a transfer. A head entry with open=0 is discarded, and nothing appears on the bus.
- R2: A transfer consists of a START (SDA falls while SCL is high), then each byte MSB first, then a ninth clock with SDA released for the acknowledge. After an acknowledged byte with close=1, the block issues a STOP (SDA rises while SCL is high), sets status bit 0 (done) and releases both lines.
- R3: SCL low and high phases each last div_i+1 clock cycles. A high phase is extended while another device holds SCL low.
- R4: If SDA reads low at the end of a high phase in which the block released it for a 1 bit, the block sets status bit 1 (arbitration lost), releases both lines, empties the queue, and issues no STOP.
- R5: If SDA reads high during the acknowledge clock, the block sets status bit 2 (not acknowledged), releases both lines, empties the queue, and issues no STOP.
- R6: If a byte with close=0 is acknowledged and the queue is empty, the block sets status bit 3 (data request) and holds SCL low. Clocking resumes only after that flag has been cleared and the queue holds an entry.
- R7: Status bit 4 reads 1 exactly when the queue is empty, and fifo_full_o reads 1 when it holds FIFO_DEPTH entries. A write while full is ignored. After reset the status word is 5'b10000.
- R8: Flags 0 to 3 are sticky. A clr_wr_i pulse clears each flag whose bit in clr_mask_i is 1.
- R9: irq_o is 1 exactly when some flag 0 to 3 is set together with its enable bit. The enables reset to 0 and are loaded from ctrl_ie_i on ctrl_wr_i.
- R10: A soft_rst_i pulse returns the engine to idle with both lines released and empties the queue. The flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCL half-period minus one, in clock cycles |
| wr_en_i | input | 1 | Push one entry into the transmit queue |
| wr_entry_i | input | 10 | Entry: {close, open, byte} |
| fifo_full_o | output | 1 | Queue holds FIFO_DEPTH entries |
| ctrl_wr_i | input | 1 | Load the interrupt enables |
| ctrl_ie_i | input | 4 | Enables for flags {data request, nack, arbitration, done} |
| soft_rst_i | input | 1 | Return the engine to idle and empty the queue |
| clr_wr_i | input | 1 | Write-one-to-clear strobe for the flags |
| clr_mask_i | input | 4 | Flags to clear |
| status_o | output | 5 | {queue empty, data request, nack, arbitration, done} |
| irq_o | output | 1 | Combined interrupt |
| scl_i | input | 1 | Sensed SCL level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sensed SDA level |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench plays the receiver. It rebuilds the bytes, START and STOP events and phase widths from the wired-AND lines, and compares the interrupt against the flags and the enables on every clock. It refuses the first byte of a transfer: a design that sends STOP on a refusal, or keeps the queued tail, shows up as an extra STOP or a nonempty queue. A rival device pulls SDA low under a 1 bit: a design that misses the loss keeps clocking, and one that sends STOP afterwards adds an event on the bus. A second scenario lets the queue run dry mid-transfer, then fills it past full while SCL is held. A design that resumes before the flag is cleared, or accepts the overflow entry, produces a byte list that differs from the expected one.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W  = 8;
  localparam int ENTRY_W = BYTE_W + 2;
  localparam int NFLAG   = 4;
  localparam int CNT_W   = $clog2(BYTE_W);

  // flag positions inside status_o
  localparam int F_DONE = 0;
  localparam int F_ARB  = 1;
  localparam int F_NACK = 2;
  localparam int F_DREQ = 3;

  typedef struct packed {
    logic              close;
    logic              open;
    logic [BYTE_W-1:0] data;
  } tx_entry_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_A,
    S_START_B,
    S_BIT_LO,
    S_BIT_HI,
    S_ACK_LO,
    S_ACK_HI,
    S_HOLD,
    S_STOP_LO,
    S_STOP_HI,
    S_STOP_END
  } eng_state_t;
endpackage

// File: rtl/i2ct_fifo.sv
module i2ct_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign dout_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_clkdiv.sv
module i2ct_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stall_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && !stall_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else if (!stall_i)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      tick_i,
  input  logic      fifo_empty_i,
  input  tx_entry_t head_i,
  input  logic      dreq_pend_i,
  input  logic      scl_i,
  input  logic      sda_i,
  output logic      pop_o,
  output logic      flush_o,
  output logic      run_o,
  output logic      stall_o,
  output logic      scl_oe_o,
  output logic      sda_oe_o,
  output logic [NFLAG-1:0] set_o
);
  eng_state_t        state_q, state_d;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  bit_q;
  logic              close_q;
  logic              pop, load, s_done, s_arb, s_nack, s_dreq, scl_rel;

  always_comb begin
    state_d = state_q;
    pop     = 1'b0;
    load    = 1'b0;
    s_done  = 1'b0;
    s_arb   = 1'b0;
    s_nack  = 1'b0;
    s_dreq  = 1'b0;
    unique case (state_q)
      S_IDLE: if (!fifo_empty_i) begin
        pop = 1'b1;
        if (head_i.open) begin
          load    = 1'b1;
          state_d = S_START_A;
        end
      end
      S_START_A: if (tick_i) state_d = S_START_B;
      S_START_B: if (tick_i) state_d = S_BIT_LO;
      S_BIT_LO:  if (tick_i) state_d = S_BIT_HI;
      S_BIT_HI: if (tick_i) begin
        if (sh_q[BYTE_W-1] && !sda_i) begin
          s_arb   = 1'b1;
          state_d = S_IDLE;
        end else if (bit_q == CNT_W'(BYTE_W - 1)) begin
          state_d = S_ACK_LO;
        end else begin
          state_d = S_BIT_LO;
        end
      end
      S_ACK_LO: if (tick_i) state_d = S_ACK_HI;
      S_ACK_HI: if (tick_i) begin
        if (sda_i) begin
          s_nack  = 1'b1;
          state_d = S_IDLE;
        end else if (close_q) begin
          state_d = S_STOP_LO;
        end else if (!fifo_empty_i) begin
          pop     = 1'b1;
          load    = 1'b1;
          state_d = S_BIT_LO;
        end else begin
          s_dreq  = 1'b1;
          state_d = S_HOLD;
        end
      end
      // bus parked with SCL low until the host refills and acknowledges
      S_HOLD: if (!dreq_pend_i && !fifo_empty_i) begin
        pop     = 1'b1;
        load    = 1'b1;
        state_d = S_BIT_LO;
      end
      S_STOP_LO:  if (tick_i) state_d = S_STOP_HI;
      S_STOP_HI:  if (tick_i) state_d = S_STOP_END;
      S_STOP_END: if (tick_i) begin
        s_done  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      close_q <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= S_IDLE;
    end else begin
      if (load) begin
        sh_q    <= head_i.data;
        close_q <= head_i.close;
        bit_q   <= '0;
      end else if (state_q == S_BIT_HI && tick_i) begin
        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
      state_q <= state_d;
    end
  end

  assign scl_oe_o = (state_q == S_START_B) || (state_q == S_BIT_LO) ||
                    (state_q == S_ACK_LO)  || (state_q == S_HOLD)   ||
                    (state_q == S_STOP_LO);
  assign sda_oe_o = (state_q == S_START_A) || (state_q == S_START_B) ||
                    (((state_q == S_BIT_LO) || (state_q == S_BIT_HI)) && !sh_q[BYTE_W-1]) ||
                    (state_q == S_STOP_LO) || (state_q == S_STOP_HI);

  assign scl_rel = (state_q == S_START_A) || (state_q == S_BIT_HI) ||
                   (state_q == S_ACK_HI)  || (state_q == S_STOP_HI) ||
                   (state_q == S_STOP_END);
  assign stall_o = scl_rel && !scl_i;
  assign run_o   = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign pop_o   = pop && !soft_rst_i;
  assign flush_o = soft_rst_i || s_arb || s_nack;

  always_comb begin
    set_o         = '0;
    set_o[F_DONE] = s_done && !soft_rst_i;
    set_o[F_ARB]  = s_arb  && !soft_rst_i;
    set_o[F_NACK] = s_nack && !soft_rst_i;
    set_o[F_DREQ] = s_dreq && !soft_rst_i;
  end
endmodule

// File: rtl/i2ct_flags.sv
module i2ct_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  flags_o[i] <= 1'b0;
      else if (set_i[i])            flags_o[i] <= 1'b1;
      else if (clr_wr_i && clr_i[i]) flags_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_i;
  end

  assign irq_o = |(flags_o & en_q);
endmodule

// File: rtl/i2c_fifo_tx_master.sv
module i2c_fifo_tx_master
  import i2ct_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               wr_en_i,
  input  logic [ENTRY_W-1:0] wr_entry_i,
  output logic               fifo_full_o,
  input  logic               ctrl_wr_i,
  input  logic [NFLAG-1:0]   ctrl_ie_i,
  input  logic               soft_rst_i,
  input  logic               clr_wr_i,
  input  logic [NFLAG-1:0]   clr_mask_i,
  output logic [NFLAG:0]     status_o,
  output logic               irq_o,
  input  logic               scl_i,
  output logic               scl_oe_o,
  input  logic               sda_i,
  output logic               sda_oe_o
);
  logic [ENTRY_W-1:0] head;
  logic               empty, pop, flush, run, stall, tick;
  logic [NFLAG-1:0]   set, flags;

  i2ct_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (wr_en_i),
    .din_i   (wr_entry_i),
    .pop_i   (pop),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (fifo_full_o)
  );

  i2ct_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .stall_i (stall),
    .div_i   (div_i),
    .tick_o  (tick)
  );

  i2ct_engine u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .tick_i       (tick),
    .fifo_empty_i (empty),
    .head_i       (tx_entry_t'(head)),
    .dreq_pend_i  (flags[F_DREQ]),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .pop_o        (pop),
    .flush_o      (flush),
    .run_o        (run),
    .stall_o      (stall),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .set_o        (set)
  );

  i2ct_flags #(.N(NFLAG)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .clr_wr_i (clr_wr_i),
    .clr_i    (clr_mask_i),
    .en_wr_i  (ctrl_wr_i),
    .en_i     (ctrl_ie_i),
    .flags_o  (flags),
    .irq_o    (irq_o)
  );

  assign status_o = {empty, flags};
endmodule

// File: rtl/i2c_fifo_tx_master_chk.sv
module i2c_fifo_tx_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       clr_wr_i,
  input logic [3:0] clr_mask_i,
  input logic [4:0] status_o,
  input logic       fifo_full_o,
  input logic       irq_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  p_done_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> (!scl_oe_o && !sda_oe_o));

  p_arb_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> (!scl_oe_o && !sda_oe_o && status_o[4]));

  p_nack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> (!scl_oe_o && !sda_oe_o && status_o[4]));

  p_dreq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> scl_oe_o);

  p_full_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full_o && status_o[4]));

  p_sticky_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !(clr_wr_i && clr_mask_i[0])) |=> status_o[0]);

  p_sticky_dreq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !(clr_wr_i && clr_mask_i[3])) |=> status_o[3]);

  p_quiet_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:0] == 4'b0) |-> !irq_o);

  p_soft_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!scl_oe_o && !sda_oe_o && status_o[4]));
endmodule

bind i2c_fifo_tx_master i2c_fifo_tx_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .clr_wr_i    (clr_wr_i),
  .clr_mask_i  (clr_mask_i),
  .status_o    (status_o),
  .fifo_full_o (fifo_full_o),
  .irq_o       (irq_o),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o)
);

// File: tb/sim_i2c_fifo_tx_master.sv
module sim_i2c_fifo_tx_master;
  localparam int DEPTH = 4;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] div;
  logic          wr_en;
  logic [9:0]    wr_entry;
  logic          full;
  logic          ctrl_wr;
  logic [3:0]    ctrl_ie;
  logic          soft_rst;
  logic          clr_wr;
  logic [3:0]    clr_mask;
  logic [4:0]    status;
  logic          irq;
  logic          scl_oe, sda_oe;
  logic          tb_ack_low = 1'b0;
  logic          rival = 1'b0;
  logic          scl_line, sda_line;

  always #10 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | tb_ack_low | rival);

  i2c_fifo_tx_master #(.FIFO_DEPTH(DEPTH), .DIV_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div),
    .wr_en_i(wr_en), .wr_entry_i(wr_entry), .fifo_full_o(full),
    .ctrl_wr_i(ctrl_wr), .ctrl_ie_i(ctrl_ie), .soft_rst_i(soft_rst),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask), .status_o(status), .irq_o(irq),
    .scl_i(scl_line), .scl_oe_o(scl_oe), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int vectors = 0, miscompares = 0;
  logic [3:0] ie_model = 4'b0;

  // receiver / bus monitor state
  logic [7:0] rx[$];
  int starts = 0, stops = 0, byte_total = 0, nack_at = -1;
  int bitcnt_m = 0, run_w = 0, last_hi = 0, last_lo = 0;
  logic [7:0] shifter = 8'h0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      // R9 reference: interrupt tracks flags and enables on every clock
      chk(irq === |(status[3:0] & ie_model), "R9 irq per clock", irq, |(status[3:0] & ie_model));
      if (scl_line == prev_scl) run_w++;
      else begin
        if (prev_scl) last_hi = run_w; else last_lo = run_w;
        run_w = 1;
      end
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        starts++;
        bitcnt_m = 0;
      end
      if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
      if (!prev_scl && scl_line) begin
        if (bitcnt_m < 8) begin
          shifter = {shifter[6:0], sda_line};
          bitcnt_m++;
          if (bitcnt_m == 8) begin
            rx.push_back(shifter);
            byte_total++;
          end
        end else bitcnt_m = 0;
      end
      if (prev_scl && !scl_line) begin
        if (bitcnt_m == 8) tb_ack_low = ((byte_total - 1) != nack_at);
        else tb_ack_low = 1'b0;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic push(input logic [9:0] e);
    @(negedge clk); wr_en = 1'b1; wr_entry = e;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_ie(input logic [3:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_ie = v;
    @(posedge clk); ie_model = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_mask = m;
    @(negedge clk); clr_wr = 1'b0; clr_mask = 4'h0;
  endtask

  task automatic wait_bit(input int b, input string req);
    int n = 0;
    while (!status[b] && n < 3000) begin @(negedge clk); n++; end
    chk(status[b] === 1'b1, req, status[b], 1);
  endtask

  initial begin
    int s0, st0, n0;
    rst_n = 1'b0; div = 8'd3; wr_en = 0; wr_entry = '0; ctrl_wr = 0; ctrl_ie = '0;
    soft_rst = 0; clr_wr = 0; clr_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk(status === 5'h10, "R7 reset status", status, 5'h10);
    chk(!irq, "R9 reset irq", irq, 0);
    chk(!scl_oe && !sda_oe, "R2 idle lines", {scl_oe, sda_oe}, 0);

    // R2 three-byte transfer, R3 timing at div=3
    push(10'h1A4); push(10'h03C); push(10'h281);
    wait_bit(0, "R2 done flag");
    chk(rx.size() == 3, "R2 byte count", rx.size(), 3);
    if (rx.size() == 3) begin
      chk(rx[0] == 8'hA4, "R2 byte0", rx[0], 8'hA4);
      chk(rx[1] == 8'h3C, "R2 byte1", rx[1], 8'h3C);
      chk(rx[2] == 8'h81, "R2 byte2", rx[2], 8'h81);
    end
    chk(starts == 1 && stops == 1, "R2 start/stop", {starts[7:0], stops[7:0]}, 16'h0101);
    chk(status[4], "R7 queue empty after", status[4], 1);
    chk(last_hi == 4, "R3 high width div3", last_hi, 4);
    chk(last_lo == 4, "R3 low width div3", last_lo, 4);

    // R10 soft reset mid-transfer keeps flags
    s0 = stops;
    push(10'h1C3); push(10'h211);
    repeat (20) @(negedge clk);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    chk(status[4], "R10 queue emptied", status[4], 1);
    chk(status[0], "R10 done flag kept", status[0], 1);
    st0 = starts;
    repeat (100) @(negedge clk);
    chk(starts == st0 && stops == s0, "R10 bus quiet", starts, st0);

    // R9 enable, R8 write-one-to-clear
    set_ie(4'b0001);
    chk(irq, "R9 irq with done enabled", irq, 1);
    clear(4'b0001);
    chk(!status[0] && !irq, "R8 done cleared", {status[0], irq}, 0);

    // R3 timing at div=1
    div = 8'd1;
    n0 = rx.size();
    push(10'h15A); push(10'h2E7);
    wait_bit(0, "R2 done at div1");
    chk(rx.size() == n0 + 2 && rx[rx.size()-1] == 8'hE7, "R2 bytes div1", rx[rx.size()-1], 8'hE7);
    chk(last_hi == 2 && last_lo == 2, "R3 widths div1", {last_hi[7:0], last_lo[7:0]}, 16'h0202);
    clear(4'b0001);
    div = 8'd3;

    // R5 refused address byte
    s0 = stops;
    nack_at = byte_total;
    push(10'h150); push(10'h060);
    wait_bit(2, "R5 nack flag");
    chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
    chk(status[4], "R5 queue emptied", status[4], 1);
    repeat (20) @(negedge clk);
    chk(stops == s0 && !status[0], "R5 no stop", stops, s0);
    nack_at = -1;
    clear(4'b0100);

    // R4 arbitration loss
    st0 = starts;
    push(10'h1FF); push(10'h200);
    for (int i = 0; i < 200 && starts == st0; i++) @(negedge clk);
    rival = 1'b1;
    wait_bit(1, "R4 arb flag");
    chk(!scl_oe && !sda_oe, "R4 lines released", {scl_oe, sda_oe}, 0);
    chk(status[4], "R4 queue emptied", status[4], 1);
    repeat (20) @(negedge clk);
    chk(stops == s0 && !status[0], "R4 no stop", stops, s0);
    rival = 1'b0;
    @(negedge clk);
    clear(4'b0010);

    // R1 entry without open marker is dropped
    st0 = starts;
    push(10'h077);
    repeat (10) @(negedge clk);
    chk(status[4] && starts == st0, "R1 dropped entry", starts, st0);

    // R6 data request hold, R7 full and overflow
    set_ie(4'b1000);
    n0 = rx.size();
    push(10'h122);
    wait_bit(3, "R6 dreq flag");
    chk(rx.size() == n0 + 1 && rx[rx.size()-1] == 8'h22, "R6 first byte", rx[rx.size()-1], 8'h22);
    repeat (50) @(negedge clk);
    chk(scl_oe && !scl_line, "R6 SCL held", scl_oe, 1);
    push(10'h031); push(10'h032); push(10'h033); push(10'h234);
    chk(full, "R7 full", full, 1);
    push(10'h099);
    repeat (20) @(negedge clk);
    chk(scl_oe && rx.size() == n0 + 1, "R6 held until clear", rx.size(), n0 + 1);
    clear(4'b1000);
    wait_bit(0, "R6 resumed to done");
    chk(rx.size() == n0 + 5, "R7 overflow ignored", rx.size(), n0 + 5);
    if (rx.size() == n0 + 5) begin
      for (int k = 0; k < 4; k++)
        chk(rx[n0 + 1 + k] == 8'h31 + k, "R6 resumed byte", rx[n0 + 1 + k], 8'h31 + k);
    end
    chk(status[4], "R7 empty at end", status[4], 1);

    repeat (10) @(negedge clk);
    summary();
  end
endmodule